// File: doc/BRIEF.md
# Systolic Local Sequence Alignment Array

This block scores a local alignment between a short query DNA sequence and a database sequence that streams past it. The query is a static input vector with one 2-bit base per processing element (PE). Database bases enter one per accepted transfer. Each base travels down a linear chain of PEs, one PE per cycle. PE `i` computes similarity-matrix cell (`i`, `j`) when database base `j` reaches it. Row 0 and column 0 of the matrix are taken as zero. Every PE therefore completes one cell update per cycle, and the array sustains a throughput of N_PE cells per clock.

Each computed cell also produces a 2-bit direction code, which records the neighbour the cell's value came from. These codes leave on a direction stream, one lane per PE, for a later traceback stage. Each PE keeps a running maximum for its own row. When the token that carries the end-of-sequence flag passes a PE, that PE merges its row maximum into a compare chain. When the token leaves the last PE, the best local score and its (query index, database column) pair are placed on a result output.

The linear gap penalty comes from a small register that software can write. A start-of-sequence flag, carried on the first base of a sequence, clears each PE's row state as that base reaches the PE. Streams use valid/ready handshakes. An input transfer happens on a clock edge where `in_valid` and `in_ready` are both high. A sender must hold its valid signal and data steady until the transfer completes. The array advances only when its direction stream can take new data and no result is waiting. Back-pressure on either output therefore stalls the whole array, and nothing is dropped.

Top module: `sw_align_array`

## Requirements
- R1: Base codes are A=00, C=01, G=10, T=11. The pair score is +10 for identical bases, 0 for a transition (A with G, C with T), and -5 for any other pair (a transversion).
- R2: Each cell is H(i,j) = max(0, H(i-1,j-1)+s, H(i-1,j)-g, H(i,j-1)-g), where g is the gap magnitude. Row 0 and column 0 are zero.
- R3: Direction codes are 00 = none, 01 = diagonal, 10 = up, 11 = left. Ties are resolved in the order diagonal, then up, then left. A cell whose result is not positive has score 0 and code 00.
- R4: A score that would exceed 2^SCORE_W-1 saturates at that value and does not wrap.
- R5: A base that carries `in_sos` is database column 0. It clears each PE's left value, diagonal value and row maximum as it reaches that PE, so no earlier sequence affects the scores. A base may carry `in_sos` and `in_eos` together.
- R6: After a base with `in_eos`, the result gives the highest score over the whole sequence. Ties go to the lowest query index, then to the lowest database column. If no cell is positive, the result is score 0 at (0, 0). A sequence that ends without `in_eos` produces no result.
- R7: The gap magnitude resets to GAP_DEFAULT (4). A cycle with `gap_we` high loads `gap_wdata`. The gap magnitude may change only while the array holds no sequence.
- R8: An input base is accepted when `in_valid && in_ready`. `in_ready` is low whenever a result is waiting, and whenever the direction stream holds data that is not being taken.
- R9: On a direction transfer, lane i of `dir_codes`/`dir_mask` carries the code of the next cell of row i, in column order. Lane i carries every column of the sequence exactly once. While `dir_valid && !dir_ready`, the direction outputs stay stable.
- R10: While `res_valid && !res_ready`, the result fields stay stable and `res_valid` stays high.
- R11: While both outputs are ready and no result is waiting, `in_ready` stays high, so one base is accepted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| query | input | 2*N_PE | Query bases; bits [2i+1:2i] hold query index i |
| gap_we | input | 1 | Load strobe for the gap magnitude |
| gap_wdata | input | SCORE_W | New gap magnitude |
| in_valid | input | 1 | Database base valid |
| in_ready | output | 1 | Array can accept a base |
| in_base | input | 2 | Database base code |
| in_sos | input | 1 | First base of a sequence |
| in_eos | input | 1 | Last base of a sequence |
| dir_valid | output | 1 | Direction stream holds at least one lane |
| dir_ready | input | 1 | Direction consumer ready |
| dir_mask | output | N_PE | Lanes carrying a code this transfer |
| dir_codes | output | 2*N_PE | Direction code per lane, lane i at [2i+1:2i] |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumer ready |
| res_score | output | SCORE_W | Best local score |
| res_qidx | output | Q_W | Query index of the best cell |
| res_col | output | COL_W | Database column of the best cell |

## Verification
A query and database built from matching fragments tests the diagonal, up and left paths and the tie priority together. All-purine sequences tell transitions apart from transversions. A query with repeated short motifs makes several cells reach the same maximum, which checks the tie rule for the result position. Changing the gap magnitude before an indel sequence shows that the left and up paths follow the register. A long run of identical bases drives scores into saturation, and fully mismatched bases check the all-zero result. A sequence left open and followed by a fresh start, a one-base sequence, and runs with pseudo-random stalls on both outputs and gaps on the input cover state clearing and the loss-free handshakes.

// File: rtl/sw_align_pkg.sv
package sw_align_pkg;

  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_DIAG = 2'b01,
    DIR_UP   = 2'b10,
    DIR_LEFT = 2'b11
  } dir_e;

  // Nucleotide codes: A=00, C=01, G=10, T=11. Purines share bit 0 = 0.
  function automatic logic signed [4:0] pair_score(input logic [1:0] qb, input logic [1:0] db);
    if (qb == db)            return 5'sd10;
    else if (qb[0] == db[0]) return 5'sd0;
    else                     return -5'sd5;
  endfunction

endpackage

// File: rtl/sw_gap_reg.sv
module sw_gap_reg #(
  parameter int SCORE_W     = 16,
  parameter int GAP_DEFAULT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [SCORE_W-1:0] wdata,
  output logic [SCORE_W-1:0] gap
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  gap <= SCORE_W'(GAP_DEFAULT);
    else if (we) gap <= wdata;
  end

  AST_GAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (gap == $past(wdata))); // R7

endmodule

// File: rtl/sw_col_counter.sv
module sw_col_counter #(
  parameter int COL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             sos,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] next_col;

  assign col = sos ? '0 : next_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    next_col <= '0;
    else if (take) next_col <= col + 1'b1;
  end

endmodule

// File: rtl/sw_pe.sv
module sw_pe
  import sw_align_pkg::*;
#(
  parameter int SCORE_W = 16,
  parameter int COL_W   = 16,
  parameter int Q_W     = 3,
  parameter int QIDX    = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic [1:0]         q_base,
  input  logic [SCORE_W-1:0] gap,
  input  logic               i_valid,
  input  logic               i_sos,
  input  logic               i_eos,
  input  logic [1:0]         i_base,
  input  logic [SCORE_W-1:0] i_h,
  input  logic [COL_W-1:0]   i_col,
  input  logic [SCORE_W-1:0] i_bscore,
  input  logic [Q_W-1:0]     i_bq,
  input  logic [COL_W-1:0]   i_bcol,
  output logic               o_valid,
  output logic               o_sos,
  output logic               o_eos,
  output logic [1:0]         o_base,
  output logic [SCORE_W-1:0] o_h,
  output logic [COL_W-1:0]   o_col,
  output logic [SCORE_W-1:0] o_bscore,
  output logic [Q_W-1:0]     o_bq,
  output logic [COL_W-1:0]   o_bcol,
  output logic [1:0]         o_dir
);

  localparam int EW = SCORE_W + 2;
  localparam logic [SCORE_W-1:0] SMAX = '1;

  logic [SCORE_W-1:0] h_left, h_diag, row_best;
  logic [COL_W-1:0]   row_col;

  logic [SCORE_W-1:0] hl, hd, rb, cell_h, nrb, cbs;
  logic [COL_W-1:0]   rc, nrc, cbc;
  logic [Q_W-1:0]     cbq;
  logic signed [4:0]    ps;
  logic signed [EW-1:0] ps_ext, c_diag, c_up, c_left, pick;
  dir_e pdir, cell_dir;

  always_comb begin
    hl = i_sos ? '0 : h_left;
    hd = i_sos ? '0 : h_diag;
    rb = i_sos ? '0 : row_best;
    rc = i_sos ? '0 : row_col;

    ps     = pair_score(q_base, i_base);
    ps_ext = {{(EW-5){ps[4]}}, ps};
    c_diag = $signed({2'b00, hd}) + ps_ext;
    c_up   = $signed({2'b00, i_h}) - $signed({2'b00, gap});
    c_left = $signed({2'b00, hl}) - $signed({2'b00, gap});

    pick = c_diag;
    pdir = DIR_DIAG;
    if (c_up > pick)   begin pick = c_up;   pdir = DIR_UP;   end
    if (c_left > pick) begin pick = c_left; pdir = DIR_LEFT; end

    if (pick <= 0) begin
      cell_h   = '0;
      cell_dir = DIR_NONE;
    end else if (pick > $signed({2'b00, SMAX})) begin
      cell_h   = SMAX;
      cell_dir = pdir;
    end else begin
      cell_h   = pick[SCORE_W-1:0];
      cell_dir = pdir;
    end

    if (cell_h > rb) begin nrb = cell_h; nrc = i_col; end
    else             begin nrb = rb;     nrc = rc;    end

    cbs = i_bscore;
    cbq = i_bq;
    cbc = i_bcol;
    if (i_eos && (nrb > i_bscore)) begin
      cbs = nrb;
      cbq = Q_W'(QIDX);
      cbc = nrc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid  <= 1'b0;
      o_sos    <= 1'b0;
      o_eos    <= 1'b0;
      o_base   <= '0;
      o_h      <= '0;
      o_col    <= '0;
      o_bscore <= '0;
      o_bq     <= '0;
      o_bcol   <= '0;
      o_dir    <= DIR_NONE;
      h_left   <= '0;
      h_diag   <= '0;
      row_best <= '0;
      row_col  <= '0;
    end else if (adv) begin
      o_valid  <= i_valid;
      o_sos    <= i_sos;
      o_eos    <= i_eos;
      o_base   <= i_base;
      o_h      <= cell_h;
      o_col    <= i_col;
      o_bscore <= cbs;
      o_bq     <= cbq;
      o_bcol   <= cbc;
      o_dir    <= cell_dir;
      if (i_valid) begin
        h_left   <= cell_h;
        h_diag   <= i_h;
        row_best <= nrb;
        row_col  <= nrc;
      end
    end
  end

  AST_NONE_IFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> ((o_dir == DIR_NONE) == (o_h == '0))); // R3

  AST_ROW_BEST_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && i_valid && !i_sos) |=> (row_best >= $past(row_best))); // R6

  AST_CHAIN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && i_valid && i_eos) |=> (o_bscore >= $past(i_bscore))); // R6

endmodule

// File: rtl/sw_align_array.sv
module sw_align_array #(
  parameter int N_PE        = 8,
  parameter int SCORE_W     = 16,
  parameter int COL_W       = 16,
  parameter int GAP_DEFAULT = 4,
  localparam int Q_W        = (N_PE > 1) ? $clog2(N_PE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*N_PE-1:0]   query,
  input  logic                gap_we,
  input  logic [SCORE_W-1:0]  gap_wdata,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_base,
  input  logic                in_sos,
  input  logic                in_eos,
  output logic                dir_valid,
  input  logic                dir_ready,
  output logic [N_PE-1:0]     dir_mask,
  output logic [2*N_PE-1:0]   dir_codes,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [SCORE_W-1:0]  res_score,
  output logic [Q_W-1:0]      res_qidx,
  output logic [COL_W-1:0]    res_col
);

  logic [SCORE_W-1:0] gap;
  logic               adv, any_lane;
  logic [COL_W-1:0]   in_col;

  logic [N_PE:0]      c_valid, c_sos, c_eos;
  logic [1:0]         c_base   [N_PE+1];
  logic [SCORE_W-1:0] c_h      [N_PE+1];
  logic [COL_W-1:0]   c_col    [N_PE+1];
  logic [SCORE_W-1:0] c_bscore [N_PE+1];
  logic [Q_W-1:0]     c_bq     [N_PE+1];
  logic [COL_W-1:0]   c_bcol   [N_PE+1];

  sw_gap_reg #(.SCORE_W(SCORE_W), .GAP_DEFAULT(GAP_DEFAULT)) u_gap (
    .clk(clk), .rst_n(rst_n), .we(gap_we), .wdata(gap_wdata), .gap(gap)
  );

  sw_col_counter #(.COL_W(COL_W)) u_col (
    .clk(clk), .rst_n(rst_n), .take(adv && in_valid), .sos(in_sos), .col(in_col)
  );

  assign any_lane  = |c_valid[N_PE:1];
  assign adv       = !res_valid && (!any_lane || dir_ready);
  assign in_ready  = adv;
  assign dir_valid = any_lane && !res_valid;
  assign dir_mask  = c_valid[N_PE:1];

  assign c_valid[0]  = in_valid;
  assign c_sos[0]    = in_sos;
  assign c_eos[0]    = in_eos;
  assign c_base[0]   = in_base;
  assign c_h[0]      = '0;
  assign c_col[0]    = in_col;
  assign c_bscore[0] = '0;
  assign c_bq[0]     = '0;
  assign c_bcol[0]   = '0;

  for (genvar gi = 0; gi < N_PE; gi++) begin : g_pe
    sw_pe #(.SCORE_W(SCORE_W), .COL_W(COL_W), .Q_W(Q_W), .QIDX(gi)) u_pe (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .q_base(query[2*gi +: 2]), .gap(gap),
      .i_valid(c_valid[gi]), .i_sos(c_sos[gi]), .i_eos(c_eos[gi]),
      .i_base(c_base[gi]), .i_h(c_h[gi]), .i_col(c_col[gi]),
      .i_bscore(c_bscore[gi]), .i_bq(c_bq[gi]), .i_bcol(c_bcol[gi]),
      .o_valid(c_valid[gi+1]), .o_sos(c_sos[gi+1]), .o_eos(c_eos[gi+1]),
      .o_base(c_base[gi+1]), .o_h(c_h[gi+1]), .o_col(c_col[gi+1]),
      .o_bscore(c_bscore[gi+1]), .o_bq(c_bq[gi+1]), .o_bcol(c_bcol[gi+1]),
      .o_dir(dir_codes[2*gi +: 2])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_score <= '0;
      res_qidx  <= '0;
      res_col   <= '0;
    end else if (res_valid) begin
      if (res_ready) res_valid <= 1'b0;
    end else if (adv && c_valid[N_PE] && c_eos[N_PE]) begin
      res_valid <= 1'b1;
      res_score <= c_bscore[N_PE];
      res_qidx  <= c_bq[N_PE];
      res_col   <= c_bcol[N_PE];
    end
  end

  AST_NO_INPUT_WHILE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready); // R8

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && !dir_ready) |=> (dir_valid && $stable(dir_mask) && $stable(dir_codes))); // R9

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_score) && $stable(res_qidx)
                                   && $stable(res_col))); // R10

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && dir_ready) |-> in_ready); // R11

endmodule

// File: tb/tb_sw_align_array.sv
module tb_sw_align_array;

  localparam int N    = 8;
  localparam int SW   = 6;
  localparam int CW   = 8;
  localparam int QW   = 3;
  localparam int SMAX = 63;

  logic clk = 1'b0;
  logic rst_n;
  logic [2*N-1:0] query;
  logic gap_we;
  logic [SW-1:0] gap_wdata;
  logic in_valid, in_ready, in_sos, in_eos;
  logic [1:0] in_base;
  logic dir_valid, dir_ready;
  logic [N-1:0] dir_mask;
  logic [2*N-1:0] dir_codes;
  logic res_valid, res_ready;
  logic [SW-1:0] res_score;
  logic [QW-1:0] res_qidx;
  logic [CW-1:0] res_col;

  always #2 clk = ~clk;

  sw_align_array #(.N_PE(N), .SCORE_W(SW), .COL_W(CW), .GAP_DEFAULT(4)) dut (
    .clk(clk), .rst_n(rst_n), .query(query), .gap_we(gap_we), .gap_wdata(gap_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_base(in_base), .in_sos(in_sos),
    .in_eos(in_eos), .dir_valid(dir_valid), .dir_ready(dir_ready), .dir_mask(dir_mask),
    .dir_codes(dir_codes), .res_valid(res_valid), .res_ready(res_ready),
    .res_score(res_score), .res_qidx(res_qidx), .res_col(res_col)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int exp_dir [N][64];
  int exp_score, exp_q, exp_col;
  int lane_cnt [N];
  int seq_len;
  int gap_cur = 4;
  bit res_expected, got_res, bp_on, thru_on;
  string cur_tag;
  logic [15:0] lfsr = 16'hACE1;
  bit prev_dir_stall, prev_res_stall;
  logic [N-1:0] prev_mask;
  logic [2*N-1:0] prev_codes;
  logic [SW-1:0] prev_score;
  logic [QW-1:0] prev_q;
  logic [CW-1:0] prev_col;

  function automatic int nt(input byte ch);
    case (ch)
      "A": return 0;
      "C": return 1;
      "G": return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int pscore(input int a, input int b);
    if (a == b) return 10;
    if ((a % 2) == (b % 2)) return 0;
    return -5;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic build_ref(input string q, input string db);
    int h [N+1][65];
    int L;
    L = db.len();
    for (int i = 0; i <= N; i++) for (int j = 0; j <= 64; j++) h[i][j] = 0;
    exp_score = 0; exp_q = 0; exp_col = 0;
    for (int i = 1; i <= N; i++) begin
      for (int j = 1; j <= L; j++) begin
        int d, u, l, p, dr;
        d = h[i-1][j-1] + pscore(nt(q[i-1]), nt(db[j-1]));
        u = h[i-1][j] - gap_cur;
        l = h[i][j-1] - gap_cur;
        p = d; dr = 1;
        if (u > p) begin p = u; dr = 2; end
        if (l > p) begin p = l; dr = 3; end
        if (p <= 0) begin p = 0; dr = 0; end
        else if (p > SMAX) p = SMAX;
        h[i][j] = p;
        exp_dir[i-1][j-1] = dr;
        if (p > exp_score) begin exp_score = p; exp_q = i - 1; exp_col = j - 1; end
      end
    end
  endtask

  task automatic monitor();
    if (prev_dir_stall)
      chk(dir_valid && dir_mask == prev_mask && dir_codes == prev_codes,
          "R9 direction held under stall", int'(dir_codes), int'(prev_codes));
    if (prev_res_stall)
      chk(res_valid && res_score == prev_score && res_qidx == prev_q && res_col == prev_col,
          "R10 result held under stall", int'(res_score), int'(prev_score));
    chk(!(res_valid && in_ready), "R8 in_ready low while result waits", int'(in_ready), 0);
    if (dir_valid && dir_ready) begin
      for (int i = 0; i < N; i++) begin
        if (dir_mask[i]) begin
          if (lane_cnt[i] < seq_len)
            chk(int'(dir_codes[2*i +: 2]) == exp_dir[i][lane_cnt[i]],
                {cur_tag, " direction code"}, int'(dir_codes[2*i +: 2]), exp_dir[i][lane_cnt[i]]);
          else
            chk(1'b0, "R9 extra lane entry", lane_cnt[i], seq_len);
          lane_cnt[i]++;
        end
      end
    end
    if (res_valid && res_ready) begin
      chk(res_expected && !got_res, "R6 result only after end flag", 1, int'(res_expected));
      chk(int'(res_score) == exp_score, {cur_tag, " R6 best score"}, int'(res_score), exp_score);
      chk(int'(res_qidx) == exp_q, {cur_tag, " R6 query index"}, int'(res_qidx), exp_q);
      chk(int'(res_col) == exp_col, {cur_tag, " R6 column"}, int'(res_col), exp_col);
      got_res = 1'b1;
    end
    prev_dir_stall = dir_valid && !dir_ready;
    prev_res_stall = res_valid && !res_ready;
    prev_mask = dir_mask; prev_codes = dir_codes;
    prev_score = res_score; prev_q = res_qidx; prev_col = res_col;
  endtask

  task automatic step(input bit v, input int base, input bit sos, input bit eos, output bit acc);
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    in_valid = v; in_base = 2'(base); in_sos = sos; in_eos = eos;
    dir_ready = bp_on ? (lfsr[0] | lfsr[4]) : 1'b1;
    res_ready = bp_on ? lfsr[7] : 1'b1;
    #1;
    monitor();
    acc = v && in_ready;
    if (thru_on && v) chk(in_ready, "R11 full-rate acceptance", int'(in_ready), 1);
  endtask

  task automatic write_gap(input int g);
    @(negedge clk);
    gap_we = 1'b1; gap_wdata = SW'(g);
    @(negedge clk);
    gap_we = 1'b0;
    gap_cur = g;
  endtask

  task automatic send_seq(input string q, input string db, input bit eos_end,
                          input bit bp, input bit gaps, input string tag);
    bit acc;
    int n;
    bit busy;
    for (int i = 0; i < N; i++) begin
      query[2*i +: 2] = 2'(nt(q[i]));
      lane_cnt[i] = 0;
    end
    build_ref(q, db);
    seq_len = db.len();
    got_res = 1'b0; res_expected = eos_end; bp_on = bp; thru_on = !bp && !gaps;
    cur_tag = tag;
    for (int k = 0; k < db.len(); k++) begin
      if (gaps && lfsr[2]) step(1'b0, 0, 1'b0, 1'b0, acc);
      do step(1'b1, nt(db[k]), k == 0, eos_end && (k == db.len() - 1), acc);
      while (!acc);
    end
    thru_on = 1'b0;
    n = 0;
    do begin
      busy = eos_end && !got_res;
      for (int i = 0; i < N; i++) if (lane_cnt[i] < seq_len) busy = 1'b1;
      if (busy) step(1'b0, 0, 1'b0, 1'b0, acc);
      n++;
    end while (busy && n < 400);
    for (int i = 0; i < N; i++)
      chk(lane_cnt[i] == seq_len, {tag, " R9 lane count"}, lane_cnt[i], seq_len);
    if (eos_end) chk(got_res, {tag, " R6 result delivered"}, int'(got_res), 1);
    bp_on = 1'b0;
    repeat (3) step(1'b0, 0, 1'b0, 1'b0, acc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; query = '0; gap_we = 1'b0; gap_wdata = '0;
    in_valid = 1'b0; in_base = '0; in_sos = 1'b0; in_eos = 1'b0;
    dir_ready = 1'b1; res_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(in_ready, "R8 reset in_ready", int'(in_ready), 1);
    chk(!dir_valid, "R9 reset dir_valid", int'(dir_valid), 0);
    chk(!res_valid, "R10 reset res_valid", int'(res_valid), 0);

    send_seq("ACGTACGT", "TTACGTACGAT", 1'b1, 1'b0, 1'b0, "R1 R2 R3 mixed");
    send_seq("AAAAGGGG", "GGGGAAAACCTT", 1'b1, 1'b0, 1'b0, "R1 transitions");
    send_seq("ACACACAC", "ACGAC", 1'b1, 1'b0, 1'b0, "R6 ties");
    write_gap(1);
    send_seq("ACGTACGT", "ACGACGT", 1'b1, 1'b0, 1'b0, "R7 gap one");
    write_gap(4);
    send_seq("ACGTACGT", "ACGACGT", 1'b1, 1'b0, 1'b0, "R7 gap four");
    send_seq("AAAAAAAA", "AAAAAAAAAA", 1'b1, 1'b0, 1'b0, "R4 saturation");
    send_seq("AAAAAAAA", "CCCTTC", 1'b1, 1'b0, 1'b0, "R6 no match");
    send_seq("ACGTACGT", "ACGTACGT", 1'b0, 1'b0, 1'b0, "R5 open sequence");
    send_seq("CCCCCCCC", "TTCT", 1'b1, 1'b0, 1'b0, "R5 restart");
    send_seq("GATTACAG", "G", 1'b1, 1'b0, 1'b0, "R5 single base");
    send_seq("ACGTTGCA", "ACGTTGCATTACGGA", 1'b1, 1'b1, 1'b1, "R8 R9 R10 stalls");
    send_seq("TGCATGCA", "GGATGCATTGCACCATGA", 1'b1, 1'b1, 1'b1, "R9 R10 stalls long");
    send_seq("CATGCATG", "CATGCATG", 1'b1, 1'b0, 1'b0, "R11 back to full rate");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule